// File: doc/BRIEF.md
# Bit-Serial Adder with State-Held Sum and Carry

This block adds two unsigned binary numbers of any length, one bit position per clock. The two operands arrive on two single-bit inputs, least significant bit first, with one bit of each operand per clock. They might come from two shift registers that share the adder's clock. A strobe marks the clocks that carry a valid bit pair. Two state flip-flops hold the result. One stores the sum bit of the most recent pair and the other stores the carry that pair produced. The stored carry enters the addition of the next pair.

The machine is a Moore machine with four states, one for each (sum, carry) combination. The outputs are the bare flip-flop values, with no logic after them. The sum bit for a pair appears one clock after that pair is accepted. After the last pair of a word, the carry output gives the carry out of the whole addition. A synchronous clear returns the machine to the all-zero state between words, so no carry passes from one word into the next.

Top module: `serial_adder_moore`

## Requirements
- R1: While synchronous reset `rst` is high at a rising clock edge, the machine enters the zero state. After that edge, `sum_o` and `carry_o` are both 0.
- R2: When `bit_valid` is high and `word_clear` is low at an edge, `sum_o` after that edge equals `x_in` xor `y_in` xor the `carry_o` value before the edge.
- R3: When `bit_valid` is high and `word_clear` is low at an edge, `carry_o` after that edge is 1 exactly when at least two of `x_in`, `y_in` and the prior `carry_o` are 1.
- R4: When `bit_valid` is low and neither `rst` nor `word_clear` is high at an edge, `sum_o` and `carry_o` keep their values, whatever `x_in` and `y_in` are.
- R5: When `word_clear` is high at an edge, both outputs become 0, even if `bit_valid` is high at that edge. The bit pair presented with the clear is discarded.
- R6: For an N-bit word fed least significant bit first, the sequence of `sum_o` values sampled one clock after each accepted pair equals bits 0 to N-1 of the operands' sum. After the last pair, `carry_o` equals bit N of that sum.
- R7: The state encoding is (carry, sum), with bit 1 the carry and bit 0 the sum. `sum_o` and `carry_o` come straight from the state flip-flops. All four states can be reached, including sum = 1 with carry = 1 (1+1 plus an incoming carry).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clear | input | 1 | Synchronous return to the zero state between words; overrides `bit_valid` |
| bit_valid | input | 1 | Current `x_in`/`y_in` pair is an operand bit to be added |
| x_in | input | 1 | Serial bit of the first operand, LSB first |
| y_in | input | 1 | Serial bit of the second operand, LSB first |
| sum_o | output | 1 | Registered sum bit of the last accepted pair |
| carry_o | output | 1 | Registered carry from the last accepted pair |

## Verification
The in-RTL assertions check the single-step rules on every clock: the sum and majority-carry update from the prior carry, the hold when the strobe is low, the precedence of clear over a valid pair, and the zero state after reset. A single-step property cannot see whole words. Multi-bit results can only be shown by the bench's scenarios: carry rippling through long runs of ones, the final carry-out after the last pair, idle gaps inside a word, and a clear that stops a carry from reaching the next word.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  // State bit 1 is the stored carry, bit 0 the stored sum.
  localparam int unsigned STATE_W = 2;
  localparam int unsigned CARRY_BIT = 1;
  localparam int unsigned SUM_BIT = 0;

  typedef enum logic [STATE_W-1:0] {
    ST_ZERO  = 2'b00,
    ST_SUM   = 2'b01,
    ST_CARRY = 2'b10,
    ST_BOTH  = 2'b11
  } sa_state_e;

  function automatic sa_state_e sa_step(input logic a, input logic b,
                                        input sa_state_e cur);
    logic cin;
    logic [STATE_W-1:0] nxt;
    cin = cur[CARRY_BIT];
    nxt[SUM_BIT]   = a ^ b ^ cin;
    nxt[CARRY_BIT] = (a & b) | (a & cin) | (b & cin);
    return sa_state_e'(nxt);
  endfunction

endpackage

// File: rtl/sa_next_state.sv
module sa_next_state
  import serial_add_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  input  sa_state_e cur_state,
  output sa_state_e add_state
);

  always_comb begin
    add_state = sa_step(a_bit, b_bit, cur_state);
  end

endmodule

// File: rtl/sa_state_reg.sv
module sa_state_reg
  import serial_add_pkg::*;
#(
  parameter sa_state_e INIT_STATE = ST_ZERO
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      load,
  input  sa_state_e d_state,
  output sa_state_e q_state
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_state <= INIT_STATE;
    end else if (load) begin
      q_state <= d_state;
    end
  end

endmodule

// File: rtl/serial_adder_moore.sv
module serial_adder_moore
  import serial_add_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic word_clear,
  input  logic bit_valid,
  input  logic x_in,
  input  logic y_in,
  output logic sum_o,
  output logic carry_o
);

  sa_state_e state_q;
  sa_state_e state_d;

  sa_next_state u_next (
    .a_bit     (x_in),
    .b_bit     (y_in),
    .cur_state (state_q),
    .add_state (state_d)
  );

  sa_state_reg #(
    .INIT_STATE (ST_ZERO)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .clr     (word_clear),
    .load    (bit_valid),
    .d_state (state_d),
    .q_state (state_q)
  );

  // Moore outputs: bare state bits (R7)
  assign sum_o   = state_q[SUM_BIT];
  assign carry_o = state_q[CARRY_BIT];

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (!sum_o && !carry_o));

  a_r2_sum_bit: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !word_clear) |=>
      (sum_o == ($past(x_in) ^ $past(y_in) ^ $past(carry_o))));

  a_r3_carry_bit: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !word_clear) |=>
      (carry_o == (($past(x_in) & $past(y_in)) |
                   ($past(x_in) & $past(carry_o)) |
                   ($past(y_in) & $past(carry_o)))));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !word_clear) |=> ($stable(sum_o) && $stable(carry_o)));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    word_clear |=> (!sum_o && !carry_o));

endmodule

// File: tb/tb_serial_adder_moore.sv
module tb_serial_adder_moore;

  localparam int W = 8;
  localparam int NVEC = 8;
  localparam logic [NVEC-1:0][2*W-1:0] VECS = {
    {8'h00, 8'h00}, {8'h01, 8'h01}, {8'hFF, 8'h01}, {8'hFF, 8'hFF},
    {8'hA5, 8'h5A}, {8'h80, 8'h80}, {8'h3C, 8'h47}, {8'h7F, 8'h7F}
  };

  logic clk = 1'b0;
  logic rst, word_clear, bit_valid, x_in, y_in;
  logic sum_o, carry_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_adder_moore dut (
    .clk(clk), .rst(rst), .word_clear(word_clear), .bit_valid(bit_valid),
    .x_in(x_in), .y_in(y_in), .sum_o(sum_o), .carry_o(carry_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 time unit after the next rising edge.
  task automatic step(input logic v, input logic c, input logic a, input logic b);
    @(negedge clk);
    bit_valid = v; word_clear = c; x_in = a; y_in = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run_word(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit gaps);
    logic [W:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    step(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < W; i++) begin
      step(1'b1, 1'b0, a[i], b[i]);
      check("R6 sum bit", sum_o, ref_sum[i]);
      if (gaps && (i % 3 == 1)) begin
        step(1'b0, 1'b0, ~a[i], ~b[i]);
        check("R4 idle sum", sum_o, ref_sum[i]);
      end
    end
    check("R6 final carry", carry_o, ref_sum[W]);
  endtask

  initial begin
    #20000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; word_clear = 1'b0; bit_valid = 1'b0; x_in = 1'b0; y_in = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R1 reset sum", sum_o, 1'b0);
    check("R1 reset carry", carry_o, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      run_word(VECS[k][2*W-1:W], VECS[k][W-1:0], 1'b0);
    end
    run_word(8'hFF, 8'h01, 1'b1);
    run_word(8'hB7, 8'hCE, 1'b1);

    // R2/R3/R7: single steps through all four states
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R3 carry after 1+1", carry_o, 1'b1);
    check("R2 sum after 1+1", sum_o, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R7 both set sum", sum_o, 1'b1);
    check("R7 both set carry", carry_o, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 carry-in only sum", sum_o, 1'b1);
    check("R3 carry-in only carry", carry_o, 1'b0);

    // R4: long idle with toggling inputs
    step(1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, i[0], i[1]);
      check("R4 hold carry", carry_o, 1'b1);
      check("R4 hold sum", sum_o, 1'b0);
    end

    // R5: clear with valid pair present
    step(1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 clear sum", sum_o, 1'b0);
    check("R5 clear carry", carry_o, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 no carry leak", sum_o, 1'b0);

    // R1: reset in the middle of a word
    step(1'b1, 1'b0, 1'b1, 1'b1);
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R1 mid reset sum", sum_o, 1'b0);
    check("R1 mid reset carry", carry_o, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule